// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block is a single baud-rate generator of the kind a communications subsystem instantiates several times, one per clock source that serial channels may select. A 32-bit control word, written in one cycle, carries three things: a run enable, a twelve-bit division ratio, and a switch that adds a fixed divide-by-sixteen stage in front of the divider. The reference clock arrives as a one-cycle enable pulse `ref_en_i` in the system clock domain.

The output is given in two forms. The first is a one-cycle `tick_o` pulse, one for each divider period, for use as a clock enable. The second is `baud_o`, a square wave that changes level on every tick. Serial receivers sample at sixteen times the bit rate, so software sets the ratio to give sixteen times the wanted baud rate. The prescale switch lets slow rates fit within the twelve-bit range.

Top module: `baud_gen`

## Requirements
- R1: After reset the stored control word is zero, so the generator is off, and `tick_o` and `baud_o` are both 0.
- R2: While the enable bit (bit 16) of the stored control word is 0, `baud_o` stays 0 and `tick_o` never pulses.
- R3: The division field sits in bits 12:1 and holds N-1. With the prescale bit at 0 and `ref_en_i` high in every cycle, `tick_o` pulses once every N cycles.
- R4: `baud_o` changes level in exactly the cycle where `tick_o` is 1, and in no other enabled cycle that is not a write. It is therefore a square wave with period 2N.
- R5: When the prescale bit (bit 0) is 1, the divider advances only on every sixteenth reference pulse. With `ref_en_i` always high, the tick period is 16·N cycles.
- R6: A control-word write takes effect at the next clock edge. It sets the counter to the new field value, clears the prescale phase, and drives `baud_o` and `tick_o` to 0. The first tick then comes N steps after the write.
- R7: In a cycle where `ref_en_i` is 0, the generator does not advance. No tick occurs and `baud_o` keeps its level.
- R8: Both ends of the range work: a field of 0 (N=1) ticks on every step, and a field of 4095 gives N=4096.
- R9: Control-word bits other than 16, 12:1 and 0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en_i | input | 1 | Reference clock enable, one pulse per reference period |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_wdata_i | input | 32 | Control-word value to store |
| tick_o | output | 1 | One-cycle pulse, one per divider period |
| baud_o | output | 1 | Square wave that changes level on each tick |

## Verification
The assertions assume two things. First, `ref_en_i` and `cfg_we_i` are clean synchronous levels with no X in any cycle after reset. Second, a write may arrive in any cycle, including one in which the divider would otherwise wrap. The bench drives its inputs on the falling edge only. It issues writes while the generator is running, with the reference enable held steady, and under an irregular enable pattern. This covers the case where a reload and a write fall in the same cycle without leaving the assumed input space.

// File: rtl/brg_pkg.sv
package brg_pkg;
   // Default layout of the control word
   localparam int unsigned BRG_CFG_W   = 32;
   localparam int unsigned BRG_DIV_W   = 12;
   localparam int unsigned BRG_DIV_LSB = 1;
   localparam int unsigned BRG_EN_BIT  = 16;
   localparam int unsigned BRG_PRE_BIT = 0;
   localparam int unsigned BRG_PRE_LOG2 = 4;

   // Source of a counter load
   typedef enum logic [1:0] {
      LD_NONE  = 2'd0,
      LD_WRITE = 2'd1,
      LD_IDLE  = 2'd2
   } brg_load_e;
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
   parameter int unsigned LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_en,
   input  logic pre_sel,
   output logic step
);
   generate
      if (LOG2 == 0) begin : g_bypass
         logic unused_ok;
         assign unused_ok = clr ^ pre_sel;
         assign step = ref_en;
      end else begin : g_count
         logic [LOG2-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                  phase_q <= '0;
            else if (clr)                phase_q <= '0;
            else if (ref_en && pre_sel)  phase_q <= phase_q + 1'b1;
         end

         assign step = ref_en & (~pre_sel | (&phase_q));

         // with the prescaler off, no reference pulse is swallowed
         AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_en && !pre_sel) |-> step); // R3

         // the phase counter stays put when it is not counting
         AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !(ref_en && pre_sel)) |=> $stable(phase_q)); // R7
      end
   endgenerate
endmodule

// File: rtl/brg_count.sv
module brg_count #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] reload_val,
   input  logic         step,
   output logic         wrap,
   output logic         tick_o,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;
   logic         tick_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign wrap    = step & at_zero & ~load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val;
         tick_q <= 1'b0;
      end else if (step) begin
         cnt_q  <= at_zero ? reload_val : cnt_q - 1'b1;
         tick_q <= at_zero;
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;
   assign cnt_o  = cnt_q;

   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> ($stable(cnt_q) && !tick_q)); // R7

   AST_TICK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> ($past(step) && !$past(load))); // R5

   AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/brg_wave.sv
module brg_wave (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic wave_o
);
   logic wave_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     wave_q <= 1'b0;
      else if (clr)   wave_q <= 1'b0;
      else if (flip)  wave_q <= ~wave_q;
   end

   assign wave_o = wave_q;

   AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !wave_q); // R6
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
   parameter int unsigned CFG_W    = brg_pkg::BRG_CFG_W,
   parameter int unsigned DIV_W    = brg_pkg::BRG_DIV_W,
   parameter int unsigned DIV_LSB  = brg_pkg::BRG_DIV_LSB,
   parameter int unsigned EN_BIT   = brg_pkg::BRG_EN_BIT,
   parameter int unsigned PRE_BIT  = brg_pkg::BRG_PRE_BIT,
   parameter int unsigned PRE_LOG2 = brg_pkg::BRG_PRE_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output logic             tick_o,
   output logic             baud_o
);
   import brg_pkg::*;

   localparam int unsigned DIV_MSB = DIV_LSB + DIV_W - 1;

   // elaboration-time layout checks
   generate
      if (DIV_MSB >= CFG_W) begin : g_bad_div
         $error("divisor field exceeds control word");
      end
      if (EN_BIT >= CFG_W || PRE_BIT >= CFG_W) begin : g_bad_bit
         $error("flag bit outside control word");
      end
      if ((EN_BIT >= DIV_LSB && EN_BIT <= DIV_MSB) ||
          (PRE_BIT >= DIV_LSB && PRE_BIT <= DIV_MSB) || EN_BIT == PRE_BIT) begin : g_overlap
         $error("control word fields overlap");
      end
   endgenerate

   // stored control fields (unused bits are never kept)
   logic             en_q;
   logic             pre_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pre_q <= 1'b0;
         div_q <= '0;
      end else if (cfg_we_i) begin
         en_q  <= cfg_wdata_i[EN_BIT];
         pre_q <= cfg_wdata_i[PRE_BIT];
         div_q <= cfg_wdata_i[DIV_MSB:DIV_LSB];
      end
   end

   brg_load_e        load_src;
   logic             clr;
   logic [DIV_W-1:0] load_val;
   logic             step;
   logic             wrap;
   logic [DIV_W-1:0] cnt;

   always_comb begin
      if (cfg_we_i)   load_src = LD_WRITE;
      else if (!en_q) load_src = LD_IDLE;
      else            load_src = LD_NONE;
   end

   assign clr      = (load_src != LD_NONE);
   assign load_val = (load_src == LD_WRITE) ? cfg_wdata_i[DIV_MSB:DIV_LSB] : div_q;

   brg_prescale #(.LOG2(PRE_LOG2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .ref_en  (ref_en_i),
      .pre_sel (pre_q),
      .step    (step)
   );

   brg_count #(.W(DIV_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (clr),
      .load_val   (load_val),
      .reload_val (div_q),
      .step       (step),
      .wrap       (wrap),
      .tick_o     (tick_o),
      .cnt_o      (cnt)
   );

   brg_wave u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .flip   (wrap),
      .wave_o (baud_o)
   );

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cfg_we_i) |=> (!baud_o && !tick_o)); // R2

   AST_TICK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> (baud_o != $past(baud_o))); // R4

   AST_FLIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we_i) && $past(en_q) && (baud_o != $past(baud_o))) |-> tick_o); // R4

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i |=> (!baud_o && !tick_o)); // R6

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_q); // R3

   AST_NO_REF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_en_i && !cfg_we_i) |=> (!tick_o && $stable(baud_o))); // R7
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ref_en;
   logic        we;
   logic [31:0] wdata;
   logic        tick;
   logic        baud;

   always #5 clk = ~clk;

   baud_gen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_en_i    (ref_en),
      .cfg_we_i    (we),
      .cfg_wdata_i (wdata),
      .tick_o      (tick),
      .baud_o      (baud)
   );

   int checks = 0;
   int errors = 0;
   int wd_cnt = 0;
   bit done   = 1'b0;
   string tag = "R1";

   // behavioural reference state
   int m_en, m_pre, m_div, m_cnt, m_pcnt, m_out, m_tick;

   task automatic chk(string r, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic model_step();
      int stp;
      if (!rst_n) begin
         m_en = 0; m_pre = 0; m_div = 0; m_cnt = 0; m_pcnt = 0; m_out = 0; m_tick = 0;
      end else if (we) begin
         m_en  = int'(wdata[16]);
         m_pre = int'(wdata[0]);
         m_div = int'((wdata >> 1) & 32'hFFF);
         m_cnt = m_div; m_pcnt = 0; m_out = 0; m_tick = 0;
      end else if (m_en == 0) begin
         m_cnt = m_div; m_pcnt = 0; m_out = 0; m_tick = 0;
      end else begin
         m_tick = 0;
         stp = (ref_en && (m_pre == 0 || m_pcnt == 15)) ? 1 : 0;
         if (ref_en && m_pre != 0) m_pcnt = (m_pcnt + 1) % 16;
         if (stp != 0) begin
            if (m_cnt == 0) begin
               m_cnt = m_div; m_out = 1 - m_out; m_tick = 1;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, int'(tick), m_tick);
      chk(tag, int'(baud), m_out);
   endtask

   task automatic wr(logic [31:0] d);
      we = 1'b1; wdata = d;
      cyc();
      we = 1'b0;
   endtask

   task automatic measure(int exp, string r);
      int k;
      while (!tick) cyc();
      k = 0;
      do begin cyc(); k++; end while (!tick && k < 70000);
      chk(r, k, exp);
   endtask

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", wd_cnt, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hold;
      int k;
      rst_n = 1'b0; ref_en = 1'b1; we = 1'b0; wdata = '0;
      repeat (3) cyc();
      rst_n = 1'b1;
      tag = "R1";
      repeat (5) cyc();
      chk("R1", int'(baud), 0);
      chk("R1", int'(tick), 0);

      // N = 5
      tag = "R3 R4";
      wr(32'h0001_0000 | (32'd4 << 1));
      repeat (20) cyc();
      measure(5, "R3");
      measure(5, "R4");

      // reference gaps
      tag = "R7";
      ref_en = 1'b0;
      hold = int'(baud);
      repeat (12) cyc();
      chk("R7", int'(baud), hold);
      for (int i = 0; i < 45; i++) begin
         ref_en = (i % 3 != 0);
         cyc();
      end
      ref_en = 1'b1;

      // range ends
      tag = "R8";
      wr(32'h0001_0000);
      measure(1, "R8");
      wr(32'h0001_0000 | (32'd4095 << 1));
      measure(4096, "R8");

      // prescale
      tag = "R5";
      wr(32'h0001_0001 | (32'd2 << 1));
      measure(48, "R5");
      for (int i = 0; i < 60; i++) begin
         ref_en = (i % 4 != 1);
         cyc();
      end
      ref_en = 1'b1;

      // rewrite while running
      tag = "R6";
      wr(32'h0001_0000 | (32'd9 << 1));
      repeat (13) cyc();
      wr(32'h0001_0000 | (32'd9 << 1));
      chk("R6", int'(baud), 0);
      k = 0;
      while (!tick && k < 100) begin cyc(); k++; end
      chk("R6", k, 10);

      // stray bits ignored
      tag = "R9";
      wr(32'hFFFF_E006);
      measure(4, "R9");
      repeat (10) cyc();

      // disable
      tag = "R2";
      wr(32'h0000_0008);
      for (int i = 0; i < 30; i++) begin
         ref_en = (i % 2 == 0);
         cyc();
         chk("R2", int'(tick), 0);
      end
      chk("R2", int'(baud), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule